// File: doc/BRIEF.md
# Fault-Injectable Binary Selector Tree

This block is a purely combinational binary tree of identical three-input cells. Together the cells realise any Boolean function of `N_LEVELS` variables. The function is programmed by a vector of `2^N_LEVELS` configuration bits. To load a function, set the bit at position j to 1 for every input combination j where the function is true, and clear all other bits. The variable vector then steers the tree, and the root presents the selected configuration bit.

Every cell can be forced, one at a time or in any mix, to compute an arbitrary three-input truth table in place of its normal selection. This lets diagnostic sequences and fault-tolerant mapping schemes be exercised against known faulty behaviour. A faulty cell still sees only its own three inputs: its level's variable, its left child and its right child.

Cells are numbered level by level, starting with the cells next to the configuration bits. Within a level they are numbered from the low-order side. The override controls of every cell are packed into two flat ports at a position computed from that level and index.

Top module: `cell_mux_tree`

## Requirements
- R1: With no override enabled, `tree_out` equals `cfg_bits[var_x]`, where `var_x` is read as an unsigned index with `var_x[0]` as its least significant bit.
- R2: With no override enabled, an all-zero `cfg_bits` gives `tree_out` = 0 and an all-one `cfg_bits` gives `tree_out` = 1 for every `var_x`.
- R3: With no override enabled, when `cfg_bits` is all ones except a single 0 at position `var_x`, `tree_out` is 0. When it is all zeros except a single 1 at that position, `tree_out` is 1.
- R4: A level-1 cell j, when it is the only cell overridden, drives `tree_out` for every `var_x` with `var_x>>1 == j`. The value is `ovr_table` bit `8*j + (4*var_x[0] + 2*cfg_bits[2j+1] + cfg_bits[2j])`. The table index is formed as {level variable, right child, left child}.
- R5: An override on any set of level-1 cells that excludes cell `var_x>>1` leaves `tree_out` equal to `cfg_bits[var_x]`.
- R6: While an override enable bit is clear, the matching 8-bit table has no effect on `tree_out`.
- R7: When only the root cell is overridden, `tree_out` equals its table bit at index 4*`var_x[N_LEVELS-1]` + 2*R + L. Here L is `cfg_bits[var_x]` with the top index bit forced to 0, and R is the same with that bit forced to 1.
- R8: The cell at level i (1..N_LEVELS) and index j is controlled by `ovr_en` bit p = 2^N_LEVELS − 2^(N_LEVELS−i+1) + j and by `ovr_table[8p +: 8]`. Cell j takes outputs 2j (left) and 2j+1 (right) of the level below, and the variable it uses is `var_x[i-1]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| var_x | input | N_LEVELS | Variable vector; bit i-1 steers level i |
| cfg_bits | input | 2^N_LEVELS | Function configuration bits, one per input combination |
| ovr_en | input | 2^N_LEVELS−1 | Per-cell override enable, flat cell numbering |
| ovr_table | input | 8·(2^N_LEVELS−1) | Per-cell 8-bit truth tables, flat cell numbering |
| tree_out | output | 1 | Root value of the tree |

## Verification
On every input change, the bound checker confirms fault-free selection, the constant and single-hole configurations, and the passing-through of untouched paths around level-1 overrides. It also confirms the truth-table result of a lone overridden leaf or root cell, computing the child values straight from the configuration bits. Only the bench's sweeps can show that overrides on middle levels land on the cell named by the flat numbering. The same holds for disabled tables being truly inert under many unrelated table contents, and for an override propagating correctly through fault-free levels above it.

// File: rtl/cell_tree_pkg.sv
package cell_tree_pkg;

    localparam int TT_W = 8;

    typedef struct packed {
        logic            en;
        logic [TT_W-1:0] table_bits;
    } cell_ovr_t;

    // Cells below level lvl (flat position of the first cell on level lvl)
    function automatic int level_base(input int n_lvls, input int lvl);
        return (1 << n_lvls) - (1 << (n_lvls - lvl + 1));
    endfunction

    // Number of cells on a given level
    function automatic int level_cells(input int n_lvls, input int lvl);
        return 1 << (n_lvls - lvl);
    endfunction

    // Truth-table lookup, index {sel, hi, lo}
    function automatic logic table_pick(input logic [TT_W-1:0] tt,
                                        input logic sel,
                                        input logic hi,
                                        input logic lo);
        return tt[{sel, hi, lo}];
    endfunction

endpackage

// File: rtl/tree_cell.sv
module tree_cell
    import cell_tree_pkg::*;
(
    input  logic      sel,
    input  logic      lo,
    input  logic      hi,
    input  cell_ovr_t ovr,
    output logic      y
);
    logic norm_y;
    logic ovr_y;

    always_comb begin
        norm_y = (lo & ~sel) | (hi & sel);
        ovr_y  = table_pick(ovr.table_bits, sel, hi, lo);
        y      = ovr.en ? ovr_y : norm_y;
    end
endmodule

// File: rtl/tree_level.sv
module tree_level
    import cell_tree_pkg::*;
#(
    parameter int OUT_W = 2,
    localparam int IN_W = 2 * OUT_W
) (
    input  logic                 sel,
    input  logic [IN_W-1:0]      din,
    input  logic [OUT_W-1:0]     en,
    input  logic [TT_W*OUT_W-1:0] tt,
    output logic [OUT_W-1:0]     dout
);
    for (genvar j = 0; j < OUT_W; j++) begin : g_cell
        cell_ovr_t cfg;
        assign cfg.en         = en[j];
        assign cfg.table_bits = tt[TT_W*j +: TT_W];

        tree_cell u_cell (
            .sel (sel),
            .lo  (din[2*j]),
            .hi  (din[2*j+1]),
            .ovr (cfg),
            .y   (dout[j])
        );
    end
endmodule

// File: rtl/cell_mux_tree.sv
module cell_mux_tree
    import cell_tree_pkg::*;
#(
    parameter int N_LEVELS = 4,
    localparam int NUM_SPEC  = 1 << N_LEVELS,
    localparam int NUM_CELLS = NUM_SPEC - 1,
    localparam int NUM_NODES = 2 * NUM_SPEC - 1
) (
    input  logic [N_LEVELS-1:0]       var_x,
    input  logic [NUM_SPEC-1:0]       cfg_bits,
    input  logic [NUM_CELLS-1:0]      ovr_en,
    input  logic [TT_W*NUM_CELLS-1:0] ovr_table,
    output logic                      tree_out
);
    if (N_LEVELS < 2 || N_LEVELS > 6) begin : g_range_bad
        $error("cell_mux_tree: N_LEVELS must lie in 2..6");
    end

    // node[0 .. NUM_SPEC-1] are configuration bits, the rest cell outputs
    logic [NUM_NODES-1:0] node;
    assign node[NUM_SPEC-1:0] = cfg_bits;

    for (genvar g = 1; g <= N_LEVELS; g++) begin : g_lvl
        localparam int CNT    = level_cells(N_LEVELS, g);
        localparam int BASE   = level_base(N_LEVELS, g);
        localparam int IN_OFF = NUM_SPEC + level_base(N_LEVELS, g - 1);
        localparam int OUT_OFF = NUM_SPEC + BASE;

        tree_level #(.OUT_W(CNT)) u_level (
            .sel  (var_x[g-1]),
            .din  (node[IN_OFF +: 2*CNT]),
            .en   (ovr_en[BASE +: CNT]),
            .tt   (ovr_table[TT_W*BASE +: TT_W*CNT]),
            .dout (node[OUT_OFF +: CNT])
        );
    end

    assign tree_out = node[NUM_NODES-1];
endmodule

// File: rtl/cell_mux_tree_chk.sv
module cell_mux_tree_chk
    import cell_tree_pkg::*;
#(
    parameter int N_LEVELS = 4,
    localparam int NUM_SPEC  = 1 << N_LEVELS,
    localparam int NUM_CELLS = NUM_SPEC - 1,
    localparam int HALF      = NUM_SPEC / 2,
    localparam int ROOT      = NUM_CELLS - 1
) (
    input  logic [N_LEVELS-1:0]       var_x,
    input  logic [NUM_SPEC-1:0]       cfg_bits,
    input  logic [NUM_CELLS-1:0]      ovr_en,
    input  logic [TT_W*NUM_CELLS-1:0] ovr_table,
    input  logic                      tree_out
);
    logic [N_LEVELS-1:0] x_lo_half;
    logic [N_LEVELS-1:0] x_hi_half;
    logic [N_LEVELS-1:0] leaf_idx;
    logic [NUM_SPEC-1:0] hot;
    logic                sel_bit;
    int                  root_pos;
    int                  leaf_pos;

    always_comb begin
        x_lo_half = var_x & ~(N_LEVELS'(1) << (N_LEVELS - 1));
        x_hi_half = var_x |  (N_LEVELS'(1) << (N_LEVELS - 1));
        leaf_idx  = var_x >> 1;
        hot       = NUM_SPEC'(1) << var_x;
        sel_bit   = cfg_bits[var_x];
        root_pos  = TT_W*ROOT + 4*int'(var_x[N_LEVELS-1])
                    + 2*int'(cfg_bits[x_hi_half]) + int'(cfg_bits[x_lo_half]);
        leaf_pos  = TT_W*int'(leaf_idx) + 4*int'(var_x[0])
                    + 2*int'(cfg_bits[var_x | N_LEVELS'(1)])
                    + int'(cfg_bits[var_x & ~N_LEVELS'(1)]);

        if (ovr_en == '0)
            AST_FAULT_FREE_SELECT: assert (tree_out == sel_bit); // R1
        if (ovr_en == '0 && cfg_bits == '0)
            AST_ALL_LOW_CFG: assert (tree_out == 1'b0); // R2
        if (ovr_en == '0 && cfg_bits == '1)
            AST_ALL_HIGH_CFG: assert (tree_out == 1'b1); // R2
        if (ovr_en == '0 && cfg_bits == ~hot)
            AST_SINGLE_HOLE: assert (tree_out == 1'b0); // R3
        if (ovr_en == '0 && cfg_bits == hot)
            AST_SINGLE_PEAK: assert (tree_out == 1'b1); // R3
        if (ovr_en == (NUM_CELLS'(1) << leaf_idx))
            AST_LEAF_OVERRIDE: assert (tree_out == ovr_table[leaf_pos]); // R4
        if (ovr_en[NUM_CELLS-1:HALF] == '0 && !ovr_en[leaf_idx])
            AST_OFF_PATH_PASS: assert (tree_out == sel_bit); // R5
        if (ovr_en == (NUM_CELLS'(1) << ROOT))
            AST_ROOT_OVERRIDE: assert (tree_out == ovr_table[root_pos]); // R7
    end
endmodule

bind cell_mux_tree cell_mux_tree_chk #(.N_LEVELS(N_LEVELS)) u_chk (
    .var_x     (var_x),
    .cfg_bits  (cfg_bits),
    .ovr_en    (ovr_en),
    .ovr_table (ovr_table),
    .tree_out  (tree_out)
);

// File: tb/cell_mux_tree_tb.sv
module cell_mux_tree_tb;
    localparam int N   = 4;
    localparam int NS  = 1 << N;
    localparam int NC  = NS - 1;
    localparam int TTW = 8 * NC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [N-1:0]   var_x     = '0;
    logic [NS-1:0]  cfg_bits  = '0;
    logic [NC-1:0]  ovr_en    = '0;
    logic [TTW-1:0] ovr_table = '0;
    logic           tree_out;

    int n_checks = 0;
    int n_fail   = 0;

    cell_mux_tree #(.N_LEVELS(N)) u_dut (
        .var_x     (var_x),
        .cfg_bits  (cfg_bits),
        .ovr_en    (ovr_en),
        .ovr_table (ovr_table),
        .tree_out  (tree_out)
    );

    function automatic int cell_pos(input int lvl, input int j);
        return NS - (1 << (N - lvl + 1)) + j;
    endfunction

    function automatic logic [31:0] mix(input logic [31:0] s);
        logic [31:0] v;
        v = s ^ 32'h9E37_79B9;
        v = v ^ (v << 13);
        v = v ^ (v >> 17);
        v = v ^ (v << 5);
        return v;
    endfunction

    // Level-by-level evaluation of the tree from the requirements
    function automatic logic model(input logic [N-1:0] x, input logic [NS-1:0] c,
                                   input logic [NC-1:0] en, input logic [TTW-1:0] tt);
        logic [NS-1:0] cur;
        logic [NS-1:0] nxt;
        int p;
        int idx;
        cur = c;
        for (int lvl = 1; lvl <= N; lvl++) begin
            nxt = '0;
            for (int j = 0; j < (NS >> lvl); j++) begin
                p = cell_pos(lvl, j);
                idx = 4*int'(x[lvl-1]) + 2*int'(cur[2*j+1]) + int'(cur[2*j]);
                if (en[p]) nxt[j] = tt[8*p + idx];
                else       nxt[j] = x[lvl-1] ? cur[2*j+1] : cur[2*j];
            end
            cur = nxt;
        end
        return cur[0];
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic apply_check(input logic [N-1:0] x, input logic [NS-1:0] c,
                               input logic [NC-1:0] en, input logic [TTW-1:0] tt,
                               input logic exp_v, input string tag);
        @(posedge clk);
        #2;
        var_x = x; cfg_bits = c; ovr_en = en; ovr_table = tt;
        @(negedge clk);
        n_checks++;
        if (tree_out !== exp_v) begin
            n_fail++;
            $display("FAIL %s: x=%0d cfg=%h en=%h actual=%b expected=%b",
                     tag, x, c, en, tree_out, exp_v);
        end
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [NS-1:0]  c;
        logic [TTW-1:0] tt;
        logic [NC-1:0]  en;
        logic [7:0]     tv;
        logic [31:0]    seed;
        logic           e;
        int             p;
        int             lvl;
        int             j;
        logic [N-1:0]   xl;
        logic [N-1:0]   xh;

        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Reset state: idle inputs give a low root (R2)
        @(negedge clk);
        n_checks++;
        if (tree_out !== 1'b0) begin
            n_fail++;
            $display("FAIL R2 reset: actual=%b expected=0", tree_out);
        end

        // R1: fault-free selection across many configurations
        seed = 32'h1234_5678;
        for (int k = 0; k < 24; k++) begin
            seed = mix(seed);
            c = seed[NS-1:0];
            for (int x = 0; x < NS; x++)
                apply_check(N'(x), c, '0, '0, c[x], "R1");
        end

        // R2: constant configurations
        for (int x = 0; x < NS; x++) begin
            apply_check(N'(x), '0, '0, '0, 1'b0, "R2");
            apply_check(N'(x), '1, '0, '0, 1'b1, "R2");
        end

        // R3: single hole / single peak travelling with the index
        for (int x = 0; x < NS; x++) begin
            apply_check(N'(x), ~(NS'(1) << x), '0, '0, 1'b0, "R3");
            apply_check(N'(x),  (NS'(1) << x), '0, '0, 1'b1, "R3");
        end

        // R6: disabled tables carry random junk
        seed = 32'hCAFE_0001;
        for (int k = 0; k < 8; k++) begin
            seed = mix(seed);
            c = seed[NS-1:0];
            for (int w = 0; w < TTW / 32 + 1; w++) begin
                seed = mix(seed);
                for (int b = 0; b < 32; b++)
                    if (32*w + b < TTW) tt[32*w + b] = seed[b];
            end
            for (int x = 0; x < NS; x++)
                apply_check(N'(x), c, '0, tt, c[x], "R6");
        end

        // Single-cell overrides on every cell, several tables
        seed = 32'h0BAD_F00D;
        for (lvl = 1; lvl <= N; lvl++) begin
            for (j = 0; j < (NS >> lvl); j++) begin
                p = cell_pos(lvl, j);
                for (int t = 0; t < 4; t++) begin
                    seed = mix(seed);
                    case (t)
                        0: tv = 8'h00;
                        1: tv = 8'hFF;
                        2: tv = 8'h69;
                        default: tv = seed[7:0];
                    endcase
                    tt = '0;
                    tt[8*p +: 8] = tv;
                    en = NC'(1) << p;
                    for (int k = 0; k < 3; k++) begin
                        seed = mix(seed);
                        c = seed[NS-1:0];
                        for (int x = 0; x < NS; x++) begin
                            if (lvl == 1) begin
                                if ((x >> 1) == j)
                                    apply_check(N'(x), c, en, tt,
                                        tv[4*(x & 1) + 2*int'(c[x | 1]) + int'(c[x & ~1])], "R4");
                                else
                                    apply_check(N'(x), c, en, tt, c[x], "R5");
                            end else if (lvl == N) begin
                                xl = N'(x) & ~(N'(1) << (N-1));
                                xh = N'(x) |  (N'(1) << (N-1));
                                apply_check(N'(x), c, en, tt,
                                    tv[4*((x >> (N-1)) & 1) + 2*int'(c[xh]) + int'(c[xl])], "R7");
                            end else begin
                                apply_check(N'(x), c, en, tt, model(N'(x), c, en, tt), "R8");
                            end
                        end
                    end
                end
            end
        end

        // R5: several level-1 cells overridden together, path cell left clean
        seed = 32'h5EED_0005;
        for (int k = 0; k < 6; k++) begin
            seed = mix(seed);
            c = seed[NS-1:0];
            tt = '1;
            for (int x = 0; x < NS; x++) begin
                en = '0;
                for (int q = 0; q < NS/2; q++)
                    if (q != (x >> 1)) en[q] = ~c[x];
                apply_check(N'(x), c, en, tt, c[x], "R5");
            end
        end

        // R8: random multi-cell mixes against the level model
        seed = 32'h7777_1111;
        for (int k = 0; k < 40; k++) begin
            seed = mix(seed);
            c = seed[NS-1:0];
            seed = mix(seed);
            en = seed[NC-1:0];
            for (int w = 0; w < TTW / 32 + 1; w++) begin
                seed = mix(seed);
                for (int b = 0; b < 32; b++)
                    if (32*w + b < TTW) tt[32*w + b] = seed[b];
            end
            for (int x = 0; x < NS; x++) begin
                e = model(N'(x), c, en, tt);
                apply_check(N'(x), c, en, tt, e, "R8");
            end
        end

        finish_run();
    end
endmodule